// File: doc/BRIEF.md
# Multiprocessor Wait-For-Event Controller

This block holds the low-power wait state for a group of processor cores that use event-based spin-locks. A core that fails to take a lock raises a one-cycle wait request. If nothing has happened since its last wait, the core is put to sleep, and `core_asleep` serves as its clock-gate enable. A core that releases a lock raises a send-event pulse. That pulse is broadcast to every core, and it carries no identity of which lock was released.

Each core keeps a one-bit pending-event flag. A send-event seen while the core is awake sets the flag, so a later wait returns at once instead of sleeping. A sleeping core is woken by any qualifying source, and each source has its own gate:

- a broadcast send-event, which is never gated;
- an IRQ, when that core's IRQ mask bit is clear;
- an FIQ, when that core's FIQ mask bit is clear;
- an asynchronous abort, when that core's abort mask bit is clear;
- a debug request, when invasive debug is enabled and the request is permitted.

On waking, the core leaves sleep and receives a one-cycle wake pulse. It then retries its lock, and it may wait again.

Top module: `wfe_ctrl`

## Requirements
- R1: After reset every core is awake, no wake pulse is high, and every pending-event flag is clear. A first wait request therefore puts the core to sleep.
- R2: A wait request from an awake core whose flag is clear, with no send-event in that cycle, sets that core's `core_asleep` bit from the next cycle.
- R3: A send-event pulse from any core sets the flag of every awake core. A later wait request from such a core does not sleep and gives no wake pulse, and it clears the flag, so the following wait request sleeps.
- R4: A send-event from any core wakes every sleeping core alike. From the next cycle `core_asleep` is 0 and `wake_pulse` is 1 for exactly one cycle, and the waking send-event leaves the flag clear.
- R5: A high `irq_in` wakes a sleeping core (exit and pulse as in R4) only when that core's `irq_mask` bit is 0. A bit value of 1 means masked.
- R6: A high `fiq_in` wakes a sleeping core only when that core's `fiq_mask` bit is 0.
- R7: A high `abort_in` wakes a sleeping core only when that core's `abort_mask` bit is 0.
- R8: A high `dbg_req` wakes a sleeping core only when both `dbg_invasive_en` and `dbg_permit` are 1 for that core.
- R9: While no qualifying source is present, a sleeping core stays asleep with `wake_pulse` low, whatever its masked or disabled raw sources do.
- R10: When a wait request and a send-event come in the same cycle, the core does not sleep. The event is consumed by that wait, so the core's next wait request sleeps.
- R11: A core woken by any source that issues a new wait request sleeps again until the next qualifying source.
- R12: A wait request from a core that is already asleep has no effect. The core stays asleep with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_req | input | NCORE | One-cycle wait request per core |
| send_evt | input | NCORE | One-cycle send-event per core, broadcast to all |
| irq_in | input | NCORE | Raw IRQ level per core |
| fiq_in | input | NCORE | Raw FIQ level per core |
| abort_in | input | NCORE | Raw asynchronous abort level per core |
| dbg_req | input | NCORE | Raw debug request per core |
| irq_mask | input | NCORE | 1 masks IRQ as a wake source |
| fiq_mask | input | NCORE | 1 masks FIQ as a wake source |
| abort_mask | input | NCORE | 1 masks abort as a wake source |
| dbg_invasive_en | input | NCORE | Invasive debug enabled per core |
| dbg_permit | input | NCORE | Debug event permitted per core |
| core_asleep | output | NCORE | Core in low-power state (clock-gate enable) |
| wake_pulse | output | NCORE | One-cycle pulse on leaving the low-power state |

## Verification
Each wake source is applied to all four cores at once, with a different mask or enable pattern per core. The set of cores that wake shows whether the gating of each source is done per core and whether the correct polarity is used. A send-event raised between waits is compared with one raised during sleep and with one raised in the same cycle as the wait. This separates setting the flag, consuming it, and clearing it on wake. Holding every raw source high with all gates closed shows that the masks stay in force during sleep. Repeating a wait request during sleep shows that a wait request cannot disturb a core that is already asleep.

// File: rtl/wfe_ctrl.sv
module wfe_ctrl #(
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] wait_req,
  input  logic [NCORE-1:0] send_evt,
  input  logic [NCORE-1:0] irq_in,
  input  logic [NCORE-1:0] fiq_in,
  input  logic [NCORE-1:0] abort_in,
  input  logic [NCORE-1:0] dbg_req,
  input  logic [NCORE-1:0] irq_mask,
  input  logic [NCORE-1:0] fiq_mask,
  input  logic [NCORE-1:0] abort_mask,
  input  logic [NCORE-1:0] dbg_invasive_en,
  input  logic [NCORE-1:0] dbg_permit,
  output logic [NCORE-1:0] core_asleep,
  output logic [NCORE-1:0] wake_pulse
);

  logic             sev_any;
  logic [NCORE-1:0] wake_src;
  logic [NCORE-1:0] ev_q;
  logic [NCORE-1:0] slp_q;
  logic [NCORE-1:0] pulse_q;

  assign sev_any  = |send_evt;
  assign wake_src = {NCORE{sev_any}}
                  | (irq_in   & ~irq_mask)
                  | (fiq_in   & ~fiq_mask)
                  | (abort_in & ~abort_mask)
                  | (dbg_req  & dbg_invasive_en & dbg_permit);

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ev_q[g]    <= 1'b0;
        slp_q[g]   <= 1'b0;
        pulse_q[g] <= 1'b0;
      end else begin
        pulse_q[g] <= 1'b0;
        if (slp_q[g]) begin
          if (wake_src[g]) begin
            slp_q[g]   <= 1'b0;
            pulse_q[g] <= 1'b1;
            if (sev_any) ev_q[g] <= 1'b0;
          end
        end else if (wait_req[g]) begin
          if (ev_q[g] || sev_any) ev_q[g]  <= 1'b0;
          else                    slp_q[g] <= 1'b1;
        end else if (sev_any) begin
          ev_q[g] <= 1'b1;
        end
      end
    end
  end

  assign core_asleep = slp_q;
  assign wake_pulse  = pulse_q;

endmodule

// File: rtl/wfe_ctrl_chk.sv
module wfe_ctrl_chk #(
  parameter int NCORE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCORE-1:0] wait_req,
  input logic [NCORE-1:0] send_evt,
  input logic [NCORE-1:0] irq_in,
  input logic [NCORE-1:0] fiq_in,
  input logic [NCORE-1:0] abort_in,
  input logic [NCORE-1:0] dbg_req,
  input logic [NCORE-1:0] irq_mask,
  input logic [NCORE-1:0] fiq_mask,
  input logic [NCORE-1:0] abort_mask,
  input logic [NCORE-1:0] dbg_invasive_en,
  input logic [NCORE-1:0] dbg_permit,
  input logic [NCORE-1:0] core_asleep,
  input logic [NCORE-1:0] wake_pulse,
  input logic [NCORE-1:0] ev_q
);

  for (genvar g = 0; g < NCORE; g++) begin : g_chk
    logic any_open;
    assign any_open = (|send_evt) || (irq_in[g] && !irq_mask[g]) ||
                      (fiq_in[g] && !fiq_mask[g]) || (abort_in[g] && !abort_mask[g]) ||
                      (dbg_req[g] && dbg_invasive_en[g] && dbg_permit[g]);

    AST_SEV_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      core_asleep[g] && (|send_evt) |=> !core_asleep[g] && wake_pulse[g] && !ev_q[g]); // R4
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse[g] |=> !wake_pulse[g]); // R4
    AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      core_asleep[g] && irq_in[g] && !irq_mask[g] |=> wake_pulse[g]); // R5
    AST_FIQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      core_asleep[g] && fiq_in[g] && !fiq_mask[g] |=> wake_pulse[g]); // R6
    AST_ABT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      core_asleep[g] && abort_in[g] && !abort_mask[g] |=> wake_pulse[g]); // R7
    AST_DBG_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      core_asleep[g] && dbg_req[g] && dbg_invasive_en[g] && dbg_permit[g] |=> wake_pulse[g]); // R8
    AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      core_asleep[g] && !any_open |=> core_asleep[g] && !wake_pulse[g]); // R9
    AST_SEV_BEATS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !core_asleep[g] && wait_req[g] && (|send_evt) |=> !core_asleep[g] && !ev_q[g]); // R10
  end

endmodule

bind wfe_ctrl wfe_ctrl_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .send_evt(send_evt),
  .irq_in(irq_in), .fiq_in(fiq_in), .abort_in(abort_in), .dbg_req(dbg_req),
  .irq_mask(irq_mask), .fiq_mask(fiq_mask), .abort_mask(abort_mask),
  .dbg_invasive_en(dbg_invasive_en), .dbg_permit(dbg_permit),
  .core_asleep(core_asleep), .wake_pulse(wake_pulse), .ev_q(ev_q)
);

// File: tb/wfe_ctrl_bench.sv
module wfe_ctrl_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] wait_req = '0, send_evt = '0;
  logic [N-1:0] irq_in = '0, fiq_in = '0, abort_in = '0, dbg_req = '0;
  logic [N-1:0] irq_mask = '0, fiq_mask = '0, abort_mask = '0;
  logic [N-1:0] dbg_invasive_en = '0, dbg_permit = '0;
  logic [N-1:0] core_asleep, wake_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wfe_ctrl #(.NCORE(N)) u_wfe_ctrl (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .send_evt(send_evt),
    .irq_in(irq_in), .fiq_in(fiq_in), .abort_in(abort_in), .dbg_req(dbg_req),
    .irq_mask(irq_mask), .fiq_mask(fiq_mask), .abort_mask(abort_mask),
    .dbg_invasive_en(dbg_invasive_en), .dbg_permit(dbg_permit),
    .core_asleep(core_asleep), .wake_pulse(wake_pulse)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_req = '0; send_evt = '0; irq_in = '0; fiq_in = '0; abort_in = '0; dbg_req = '0;
    irq_mask = '0; fiq_mask = '0; abort_mask = '0; dbg_invasive_en = '0; dbg_permit = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic pulse_wait(logic [N-1:0] m);
    wait_req = m; step(); wait_req = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "asleep after reset", core_asleep, '0);
    chk("R1", "pulse after reset", wake_pulse, '0);
    pulse_wait('1);
    chk("R1", "first wait sleeps (flags clear)", core_asleep, '1);
  endtask

  task automatic t_wait_sleep();
    do_reset();
    pulse_wait(4'b0001);
    chk("R2", "wait with clear flag sleeps", core_asleep, 4'b0001);
    chk("R2", "no pulse on entry", wake_pulse, '0);
  endtask

  task automatic t_latch();
    do_reset();
    send_evt = 4'b0010; step(); send_evt = '0;
    chk("R3", "send while awake does not sleep", core_asleep, '0);
    pulse_wait('1);
    chk("R3", "wait with flag set returns", core_asleep, '0);
    chk("R3", "no pulse on immediate return", wake_pulse, '0);
    pulse_wait('1);
    chk("R3", "flag consumed, next wait sleeps", core_asleep, '1);
  endtask

  task automatic t_bcast();
    do_reset();
    pulse_wait('1);
    send_evt = 4'b1000; step(); send_evt = '0;
    chk("R4", "send wakes all sleepers", core_asleep, '0);
    chk("R4", "wake pulse to all", wake_pulse, '1);
    step();
    chk("R4", "pulse lasts one cycle", wake_pulse, '0);
    pulse_wait('1);
    chk("R11", "rewait after wake sleeps (flag clear)", core_asleep, '1);
  endtask

  task automatic t_irq();
    do_reset();
    pulse_wait('1);
    irq_mask = 4'b1010; irq_in = '1; step(); irq_in = '0;
    chk("R5", "irq wakes unmasked cores", wake_pulse, 4'b0101);
    chk("R5", "masked cores stay asleep", core_asleep, 4'b1010);
    step();
    chk("R9", "masked cores still asleep", core_asleep, 4'b1010);
    pulse_wait(4'b0101);
    chk("R11", "irq-woken cores sleep again", core_asleep, '1);
  endtask

  task automatic t_fiq();
    do_reset();
    pulse_wait('1);
    fiq_mask = 4'b0011; fiq_in = '1; step(); fiq_in = '0;
    chk("R6", "fiq wakes unmasked cores", wake_pulse, 4'b1100);
    chk("R6", "fiq masked cores asleep", core_asleep, 4'b0011);
  endtask

  task automatic t_abt();
    do_reset();
    pulse_wait('1);
    abort_mask = 4'b0110; abort_in = '1; step(); abort_in = '0;
    chk("R7", "abort wakes unmasked cores", wake_pulse, 4'b1001);
    chk("R7", "abort masked cores asleep", core_asleep, 4'b0110);
  endtask

  task automatic t_dbg();
    do_reset();
    pulse_wait('1);
    dbg_invasive_en = 4'b1100; dbg_permit = 4'b1010; dbg_req = '1; step(); dbg_req = '0;
    chk("R8", "debug wakes only enabled+permitted", wake_pulse, 4'b1000);
    chk("R8", "other cores asleep", core_asleep, 4'b0111);
  endtask

  task automatic t_masked();
    do_reset();
    pulse_wait('1);
    irq_mask = '1; fiq_mask = '1; abort_mask = '1;
    dbg_invasive_en = 4'b0101; dbg_permit = 4'b1010;
    irq_in = '1; fiq_in = '1; abort_in = '1; dbg_req = '1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R9", "all gated, stay asleep", core_asleep, '1);
      chk("R9", "all gated, no pulse", wake_pulse, '0);
    end
    irq_in = '0; fiq_in = '0; abort_in = '0; dbg_req = '0;
  endtask

  task automatic t_race();
    do_reset();
    wait_req = 4'b0001; send_evt = 4'b0010; step();
    wait_req = '0; send_evt = '0;
    chk("R10", "send beats same-cycle wait", core_asleep, '0);
    pulse_wait(4'b0011);
    chk("R10", "consumed on core0, pending on core1", core_asleep, 4'b0001);
  endtask

  task automatic t_ignore();
    do_reset();
    pulse_wait(4'b0001);
    wait_req = 4'b0001;
    step(); step();
    wait_req = '0;
    chk("R12", "wait while asleep keeps sleep", core_asleep, 4'b0001);
    chk("R12", "wait while asleep no pulse", wake_pulse, '0);
    send_evt = 4'b0100; step(); send_evt = '0;
    chk("R12", "still wakes normally after", wake_pulse, 4'b0001);
  endtask

  initial begin
    t_reset();
    t_wait_sleep();
    t_latch();
    t_bcast();
    t_irq();
    t_fiq();
    t_abt();
    t_dbg();
    t_masked();
    t_race();
    t_ignore();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule